// File: doc/BRIEF.md
# Jitter Attenuator Elastic Bit Store

This block is the one-bit-wide elastic buffer that sits between a jittered, recovered clock and the smoothed clock produced by a digital PLL. Both clocks reach it as enables inside one fast clock domain. A write strobe stores one incoming bit per recovered-clock tick. A read strobe removes one bit per smoothed-clock tick. The current occupancy is exported so that the PLL can steer its output frequency toward the average input rate.

Four features go beyond a plain FIFO:

- **Error indicators.** Overflow (a write into a full store) and underrun (a read from an empty store) each set a sticky flag. Each flag has its own enable into a single interrupt line.
- **Limit mode.** The store raises guard-band signals when it is within one bit of either extreme, so the PLL can pull its frequency before data is lost.
- **Centering.** A one-cycle command snaps the read pointer to half depth behind the write pointer.
- **Bypass.** A bypass mode routes the input bit straight to the output and freezes the storage.

Top module: `jit_elastic_store`

## Requirements
- R1: After reset the fill level is DEPTH/2 (24 by default), both sticky flags and the interrupt are 0, and the output bit is 0. The half-depth start-up content reads out as zeros.
- R2: With bypass off, bits come out in the order they were written. An accepted read (read strobe while fill > 0) updates the output bit one clock after the strobe. A lone accepted write raises fill by one, and a lone accepted read lowers it by one.
- R3: A write strobe while fill equals DEPTH and no read is accepted is an overflow. The bit is dropped, fill stays at DEPTH, and the overflow flag is 1 on the next cycle.
- R4: A read strobe while fill is 0 is an underrun. The output bit keeps its previous value, fill does not go below 0, and the underrun flag is 1 on the next cycle.
- R5: Each sticky flag stays at 1 until a cycle with the clear strobe high. If a new event and the clear strobe occur in the same cycle, the flag ends at 1.
- R6: The interrupt is 1 exactly when (overflow flag AND overflow enable) OR (underrun flag AND underrun enable).
- R7: With limit mode on, near_full is 1 when fill >= DEPTH-GUARD and near_empty is 1 when fill <= GUARD (GUARD = 1 by default). With limit mode off, both are 0.
- R8: A center strobe with bypass off sets fill to DEPTH/2 on the next cycle. The next DEPTH/2 reads return the DEPTH/2 most recently written bits, oldest first. Read and write strobes in the center cycle are ignored, and no flag is set.
- R9: While bypass is 1, the output bit equals the input bit in the same cycle, with no register in the path. Read, write and center strobes change neither the fill level nor the flags.
- R10: A simultaneous read and write at fill DEPTH are both accepted, with no overflow and fill unchanged. A simultaneous read and write at fill 0 is an underrun: the output holds, the bit is stored, and fill becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by both rate enables |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Recovered-clock enable: store wr_bit |
| wr_bit | input | 1 | Incoming jittered data bit |
| rd_stb | input | 1 | Smoothed-clock enable: emit the next bit |
| rd_bit | output | 1 | Outgoing data bit (input bit when bypassed) |
| bypass | input | 1 | Route input to output and freeze the store |
| limit_en | input | 1 | Enable the guard-band outputs |
| center_stb | input | 1 | One-cycle request to recenter the read pointer |
| err_clr | input | 1 | One-cycle clear of both sticky flags |
| ovf_ie | input | 1 | Overflow interrupt enable |
| unf_ie | input | 1 | Underrun interrupt enable |
| fill | output | 6 | Current occupancy in bits (width $clog2(DEPTH+1)) |
| near_full | output | 1 | Within GUARD bits of full (limit mode) |
| near_empty | output | 1 | Within GUARD bits of empty (limit mode) |
| ovf_flag | output | 1 | Sticky overflow indicator |
| unf_flag | output | 1 | Sticky underrun indicator |
| irq | output | 1 | Masked OR of the sticky flags |

## Verification
The bound checker checks the following on every cycle:

- the fill bound and its behaviour at the full and empty edges,
- that each sticky flag rises after its event and persists until cleared,
- that the interrupt never rises without an enabled flag,
- the guard-band thresholds,
- the fill level after a center request,
- that bypass freezes the fill level.

Data ordering needs the directed scenarios in the bench, because only they track the bit sequence across many strobes. The same holds for the repeated bit on underrun, for which bits survive a recenter, for the same-cycle clear-versus-set priority, and for the combinational bypass path.

// File: rtl/jes_pkg.sv
`timescale 1ns/1ps
package jes_pkg;
   // index of each sticky error kind inside the error vectors
   localparam int ERR_OVF = 0;
   localparam int ERR_UNF = 1;
   localparam int NUM_ERR = 2;

   // per-cycle requests presented to the pointer controller
   typedef struct packed {
      logic wr;
      logic rd;
      logic ctr;
      logic hold;
   } jes_req_t;
endpackage

// File: rtl/jes_bit_ram.sv
`timescale 1ns/1ps
module jes_bit_ram #(
   parameter int DEPTH = 48,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic          rbit
);
   logic [DEPTH-1:0] cells_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (we && (waddr == AW'(i))) cells_q[i] <= wbit;
         end
      end
   end

   // output bit register: only an accepted read refreshes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rbit <= 1'b0;
      else if (re) rbit <= cells_q[raddr];
   end
endmodule

// File: rtl/jes_ptr_ctrl.sv
`timescale 1ns/1ps
module jes_ptr_ctrl
   import jes_pkg::*;
#(
   parameter int DEPTH = 48,
   parameter int AW    = 6,
   parameter int CW    = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  jes_req_t       req,
   output logic           we,
   output logic           re,
   output logic [AW-1:0]  waddr,
   output logic [AW-1:0]  raddr,
   output logic [CW-1:0]  occ,
   output logic           ovf_ev,
   output logic           unf_ev
);
   localparam int            HALF   = DEPTH / 2;
   localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
   localparam logic [AW-1:0] HALF_P = AW'(HALF);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_C = CW'(HALF);

   logic [AW-1:0] wp_q, rp_q, rp_center;
   logic [CW-1:0] occ_q;
   logic          is_full, is_empty, active, do_center;

   assign is_full   = (occ_q == FULL_C);
   assign is_empty  = (occ_q == '0);
   assign active    = !req.hold && !req.ctr;
   assign do_center = !req.hold && req.ctr;

   // a read is only taken from a non-empty store; a write needs room,
   // or a slot freed by a read accepted in the same cycle
   assign re     = active && req.rd && !is_empty;
   assign we     = active && req.wr && (!is_full || re);
   assign ovf_ev = active && req.wr && is_full && !re;
   assign unf_ev = active && req.rd && is_empty;

   // read pointer placed HALF slots behind the write pointer, modulo DEPTH
   assign rp_center = (wp_q >= HALF_P) ? (wp_q - HALF_P) : (wp_q + HALF_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= HALF_P;
         rp_q  <= '0;
         occ_q <= HALF_C;
      end else if (do_center) begin
         rp_q  <= rp_center;
         occ_q <= HALF_C;
      end else begin
         if (we) wp_q <= (wp_q == LAST_P) ? '0 : wp_q + 1'b1;
         if (re) rp_q <= (rp_q == LAST_P) ? '0 : rp_q + 1'b1;
         unique case ({we, re})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   assign waddr = wp_q;
   assign raddr = rp_q;
   assign occ   = occ_q;
endmodule

// File: rtl/jes_err_sticky.sv
`timescale 1ns/1ps
module jes_err_sticky #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set,
   input  logic [NUM-1:0] en,
   input  logic           clr,
   output logic [NUM-1:0] flag,
   output logic           irq
);
   for (genvar k = 0; k < NUM; k++) begin : g_flag
      // a new event outranks a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[k] <= 1'b0;
         else if (set[k]) flag[k] <= 1'b1;
         else if (clr)    flag[k] <= 1'b0;
      end
   end

   assign irq = |(flag & en);
endmodule

// File: rtl/jit_elastic_store.sv
`timescale 1ns/1ps
module jit_elastic_store
   import jes_pkg::*;
#(
   parameter int DEPTH = 48,
   parameter int GUARD = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_stb,
   input  logic                           wr_bit,
   input  logic                           rd_stb,
   output logic                           rd_bit,
   input  logic                           bypass,
   input  logic                           limit_en,
   input  logic                           center_stb,
   input  logic                           err_clr,
   input  logic                           ovf_ie,
   input  logic                           unf_ie,
   output logic [$clog2(DEPTH+1)-1:0]     fill,
   output logic                           near_full,
   output logic                           near_empty,
   output logic                           ovf_flag,
   output logic                           unf_flag,
   output logic                           irq
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   // elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("jit_elastic_store: DEPTH must be even and at least 4");
   end
   if (GUARD < 0 || GUARD >= DEPTH / 2) begin : g_bad_guard
      $error("jit_elastic_store: GUARD must lie in [0, DEPTH/2)");
   end

   jes_req_t         req;
   logic             we, re, ovf_ev, unf_ev, store_bit;
   logic [AW-1:0]    waddr, raddr;
   logic [CW-1:0]    occ;
   logic [NUM_ERR-1:0] err_set, err_en, err_flag;

   assign req.wr   = wr_stb;
   assign req.rd   = rd_stb;
   assign req.ctr  = center_stb;
   assign req.hold = bypass;

   jes_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .we     (we),
      .re     (re),
      .waddr  (waddr),
      .raddr  (raddr),
      .occ    (occ),
      .ovf_ev (ovf_ev),
      .unf_ev (unf_ev)
   );

   jes_bit_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wbit  (wr_bit),
      .re    (re),
      .raddr (raddr),
      .rbit  (store_bit)
   );

   assign err_set[ERR_OVF] = ovf_ev;
   assign err_set[ERR_UNF] = unf_ev;
   assign err_en[ERR_OVF]  = ovf_ie;
   assign err_en[ERR_UNF]  = unf_ie;

   jes_err_sticky #(.NUM(NUM_ERR)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .en    (err_en),
      .clr   (err_clr),
      .flag  (err_flag),
      .irq   (irq)
   );

   assign ovf_flag = err_flag[ERR_OVF];
   assign unf_flag = err_flag[ERR_UNF];

   // guard band: a zero-width band removes the comparators altogether
   if (GUARD == 0) begin : g_no_guard
      assign near_full  = limit_en && (occ == CW'(DEPTH));
      assign near_empty = limit_en && (occ == '0);
   end else begin : g_guard
      localparam logic [CW-1:0] NF_TH = CW'(DEPTH - GUARD);
      localparam logic [CW-1:0] NE_TH = CW'(GUARD);
      assign near_full  = limit_en && (occ >= NF_TH);
      assign near_empty = limit_en && (occ <= NE_TH);
   end

   assign fill   = occ;
   assign rd_bit = bypass ? wr_bit : store_bit;
endmodule

// File: rtl/jes_checker.sv
`timescale 1ns/1ps
module jes_checker #(
   parameter int DEPTH = 48,
   parameter int GUARD = 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_stb,
   input logic                       rd_stb,
   input logic                       bypass,
   input logic                       limit_en,
   input logic                       center_stb,
   input logic                       err_clr,
   input logic                       ovf_ie,
   input logic                       unf_ie,
   input logic [$clog2(DEPTH+1)-1:0] fill,
   input logic                       near_full,
   input logic                       near_empty,
   input logic                       ovf_flag,
   input logic                       unf_flag,
   input logic                       irq
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
   localparam logic [CW-1:0] NF_TH  = CW'(DEPTH - GUARD);
   localparam logic [CW-1:0] NE_TH  = CW'(GUARD);

   logic plain;
   assign plain = !bypass && !center_stb;

   p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_C);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && wr_stb && !rd_stb && fill == FULL_C) |=> (ovf_flag && fill == FULL_C));

   p_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && rd_stb && fill == '0) |=> (unf_flag && fill <= CW'(1)));

   p_sticky_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !err_clr) |=> ovf_flag);

   p_sticky_unf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_flag && !err_clr) |=> unf_flag);

   p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((ovf_flag && ovf_ie) || (unf_flag && unf_ie)));

   p_near_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_en && fill >= NF_TH) |-> near_full);

   p_near_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_en && fill <= NE_TH) |-> near_empty);

   p_limit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !limit_en |-> (!near_full && !near_empty));

   p_center_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (center_stb && !bypass) |=> fill == HALF_C);

   p_bypass_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> fill == $past(fill));
endmodule

bind jit_elastic_store jes_checker #(.DEPTH(DEPTH), .GUARD(GUARD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .rd_stb     (rd_stb),
   .bypass     (bypass),
   .limit_en   (limit_en),
   .center_stb (center_stb),
   .err_clr    (err_clr),
   .ovf_ie     (ovf_ie),
   .unf_ie     (unf_ie),
   .fill       (fill),
   .near_full  (near_full),
   .near_empty (near_empty),
   .ovf_flag   (ovf_flag),
   .unf_flag   (unf_flag),
   .irq        (irq)
);

// File: tb/jit_elastic_store_test.sv
`timescale 1ns/1ps
module jit_elastic_store_test;
   localparam int DEPTH = 48;
   localparam int GUARD = 1;
   localparam int HALF  = DEPTH / 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_stb = 0, wr_bit = 0, rd_stb = 0, bypass = 0, limit_en = 0;
   logic center_stb = 0, err_clr = 0, ovf_ie = 0, unf_ie = 0;
   logic rd_bit, near_full, near_empty, ovf_flag, unf_flag, irq;
   logic [5:0] fill;

   always #2.5 clk = ~clk;

   jit_elastic_store #(.DEPTH(DEPTH), .GUARD(GUARD)) uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bit(wr_bit),
      .rd_stb(rd_stb), .rd_bit(rd_bit), .bypass(bypass), .limit_en(limit_en),
      .center_stb(center_stb), .err_clr(err_clr), .ovf_ie(ovf_ie),
      .unf_ie(unf_ie), .fill(fill), .near_full(near_full),
      .near_empty(near_empty), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
      .irq(irq)
   );

   int n_run = 0, n_fail = 0;
   bit done = 0;
   bit mq[$];
   bit m_out = 0, m_ovf = 0, m_unf = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one clock with the given strobes, then update the reference model
   task automatic cyc(input bit w, input bit wb, input bit r, input bit c);
      bit rd_ok, wr_ok;
      wr_stb = w; wr_bit = wb; rd_stb = r; err_clr = c;
      @(posedge clk); #1;
      wr_stb = 0; rd_stb = 0; err_clr = 0;
      rd_ok = r && (mq.size() > 0);
      wr_ok = w && ((mq.size() < DEPTH) || rd_ok);
      if (c) begin m_ovf = 0; m_unf = 0; end
      if (w && !wr_ok) m_ovf = 1;
      if (r && !rd_ok) m_unf = 1;
      if (rd_ok) m_out = mq.pop_front();
      if (wr_ok) mq.push_back(wb);
   endtask

   task automatic chk_model(input string req);
      check(req, "fill", fill, mq.size());
      check(req, "rd_bit", rd_bit, m_out);
      check(req, "ovf_flag", ovf_flag, m_ovf);
      check(req, "unf_flag", unf_flag, m_unf);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < HALF; i++) mq.push_back(1'b0);
      check("R1", "fill", fill, HALF);
      check("R1", "rd_bit", rd_bit, 0);
      check("R1", "flags", {ovf_flag, unf_flag}, 0);
      check("R1", "irq", irq, 0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 40; i++) begin
         cyc(1'b1, ((i * 5) % 3) == 1, 1'b1, 1'b0);
         check("R2", "rd_bit in order", rd_bit, m_out);
      end
      for (int i = 0; i < 5; i++) cyc(1'b1, i[0], 1'b0, 1'b0);
      check("R2", "fill after writes", fill, HALF + 5);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk_model("R2");
   endtask

   task automatic t_overflow();
      limit_en = 1; ovf_ie = 1;
      while (mq.size() < DEPTH - 1) cyc(1'b1, 1'b1, 1'b0, 1'b0);
      check("R7", "near_full at DEPTH-1", near_full, 1);
      check("R7", "near_empty at DEPTH-1", near_empty, 0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      check("R3", "fill full", fill, DEPTH);
      check("R3", "ovf before event", ovf_flag, 0);
      cyc(1'b1, 1'b1, 1'b0, 1'b0);
      check("R3", "fill after overflow", fill, DEPTH);
      check("R3", "ovf flag", ovf_flag, 1);
      check("R6", "irq enabled", irq, 1);
      ovf_ie = 0; #1;
      check("R6", "irq masked", irq, 0);
      limit_en = 0; #1;
      check("R7", "limit off", {near_full, near_empty}, 0);
   endtask

   task automatic t_full_rw();
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      cyc(1'b1, 1'b1, 1'b1, 1'b0);
      check("R10", "no ovf on full read+write", ovf_flag, 0);
      chk_model("R10");
   endtask

   task automatic t_sticky();
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      repeat (5) cyc(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5", "ovf held", ovf_flag, 1);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R5", "ovf cleared", ovf_flag, 0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1);
      check("R5", "set beats clear", ovf_flag, 1);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      chk_model("R3");
   endtask

   task automatic t_underrun();
      limit_en = 1; unf_ie = 1;
      while (mq.size() > 1) begin
         cyc(1'b0, 1'b0, 1'b1, 1'b0);
         check("R2", "drain order", rd_bit, m_out);
      end
      check("R7", "near_empty at 1", near_empty, 1);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      check("R7", "near_empty at 0", near_empty, 1);
      check("R4", "unf before event", unf_flag, 0);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      check("R4", "unf flag", unf_flag, 1);
      check("R4", "fill stays 0", fill, 0);
      check("R4", "rd_bit repeated", rd_bit, m_out);
      check("R6", "irq unf", irq, 1);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      cyc(1'b1, ~m_out, 1'b1, 1'b0);
      check("R10", "empty rw unf", unf_flag, 1);
      check("R10", "empty rw fill", fill, 1);
      check("R10", "empty rw holds out", rd_bit, m_out);
      cyc(1'b0, 1'b0, 1'b1, 1'b1);
      chk_model("R10");
      limit_en = 0; unf_ie = 0;
   endtask

   task automatic t_center();
      for (int i = 0; i < 35; i++) cyc(1'b1, (i % 4) < 2, 1'b0, 1'b0);
      wr_stb = 1; wr_bit = 1; rd_stb = 1; center_stb = 1;
      @(posedge clk); #1;
      wr_stb = 0; rd_stb = 0; center_stb = 0;
      while (mq.size() > HALF) void'(mq.pop_front());
      check("R8", "fill after center", fill, HALF);
      check("R8", "no flags", {ovf_flag, unf_flag}, 0);
      for (int i = 0; i < HALF; i++) begin
         cyc(1'b0, 1'b0, 1'b1, 1'b0);
         check("R8", "recent bits kept", rd_bit, m_out);
      end
      chk_model("R8");
   endtask

   task automatic t_bypass();
      logic [5:0] f0;
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
      f0 = fill;
      bypass = 1; wr_bit = 1; #1;
      check("R9", "pass-through 1", rd_bit, 1);
      wr_bit = 0; #1;
      check("R9", "pass-through 0", rd_bit, 0);
      wr_stb = 1; rd_stb = 1; center_stb = 1;
      repeat (4) @(posedge clk);
      #1 wr_stb = 0; rd_stb = 0; center_stb = 0;
      check("R9", "fill frozen", fill, f0);
      check("R9", "flags untouched", {ovf_flag, unf_flag}, 0);
      rd_stb = 1;
      repeat (10) @(posedge clk);
      #1 rd_stb = 0;
      check("R9", "reads ignored", fill, f0);
      bypass = 0; #1;
      chk_model("R9");
   endtask

   initial begin
      t_reset();
      t_order();
      t_overflow();
      t_full_rw();
      t_sticky();
      t_underrun();
      t_center();
      t_bypass();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule